// File: doc/BRIEF.md
# Interleaved Matrix Tile Slice Mover

This block holds a square byte matrix of SVL rows by SVL bytes in internal registers. The matrix is shared by several tiles that are interleaved row by row: with elements of N bytes there are N tiles, and row m of tile t sits in storage row t + N*m. A command port moves a vector into one column slice of a tile, copies a column slice out into a vector result, or clears storage rows chosen by an 8-bit mask. A per-byte predicate selects which elements a move touches.

Because of the interleave, element j of a column slice with N-byte elements always lands in storage row t + N*j. Its bytes sit at columns s*N to s*N+N-1 of that row, where s is the slice index. So data written with one element size can be read back with another, at the same byte positions. Each command takes effect on the clock edge that samples it. A done pulse follows on the next cycle. A copy-out result is held in a register until the next copy-out.

Top module: `interleaved_tile_mover`

## Requirements
- R1: After reset, done is 0, vec_out is all zero, and every storage byte reads back as zero.
- R2: A command sampled with cmd_valid high gives done high for exactly the next cycle. With cmd_valid low, done is low in the following cycle.
- R3: cmd_op encodings are 00 move vector into slice, 01 move slice out to vector, 10 zero rows, 11 reserved. cmd_esz 0..4 selects element sizes of 1, 2, 4, 8 and 16 bytes. On a move-in with tile t, slice s and N-byte elements, vector byte j*N+w is written to storage row t+N*j, column s*N+w.
- R4: An element is active when cmd_pred bit j*N (its lowest byte) is 1. On a move-in, the storage bytes of inactive elements keep their previous contents.
- R5: On a move-out, vec_out is loaded one edge later with the slice bytes, using the R3 mapping, for active elements. For inactive elements it is loaded with the matching bytes of cmd_vec, which carries the old destination value.
- R6: A slice written with one element size reads back through any other size at the same storage rows and columns. Example: 4-byte tile 1 slice 0 puts vector bytes 0,4,8,12 into rows 1,5,9,13 of column 0.
- R7: A zero command clears storage row i exactly when cmd_zmask bit (i mod 8) is 1. All other rows are unchanged.
- R8: A zero mask of 8'hFF clears the whole storage in a single command.
- R9: A 16-byte element is stored with its low 64 bits in the lower 8 columns of its row slot and its high 64 bits in the upper 8.
- R10: vec_out changes only on a move-out command. A reserved command changes neither the storage nor vec_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Operation code (R3) |
| cmd_esz | input | 3 | Element size code (R3) |
| cmd_tile | input | 4 | Tile number, below the element byte count |
| cmd_slice | input | log2(SVL) | Column slice index, in elements |
| cmd_zmask | input | 8 | Row mask for the zero command |
| cmd_pred | input | SVL | One predicate bit per vector byte |
| cmd_vec | input | 8*SVL | Source vector, or old destination value for a move-out |
| done | output | 1 | Pulses one cycle after each command |
| vec_out | output | 8*SVL | Result of the latest move-out |

## Verification
The assertions assume that every move command names a legal slot. The element size code is at most 4, the tile number is below the element byte count, and the slice index times the element byte count stays below SVL. Commands outside these bounds would alias rows of other tiles. The bench only draws tile and slice values inside these bounds for each size, including the largest legal tile and slice. Zero and reserved commands may carry any tile and slice values, since those fields are not decoded for them.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
  typedef enum logic [1:0] {
    OP_COL_WR = 2'b00,
    OP_COL_RD = 2'b01,
    OP_ZERO   = 2'b10,
    OP_RSVD   = 2'b11
  } tsm_op_e;

  localparam int ESZ_W  = 3;
  localparam int TILE_W = 4;
  localparam int MASK_W = 8;
endpackage

// File: rtl/tsm_lane_map.sv
// Maps one vector byte lane onto its storage row and column for the
// commanded element size, tile and slice, and reports its predicate.
module tsm_lane_map
  import tsm_pkg::*;
#(
  parameter int SVL  = 16,
  parameter int LANE = 0
) (
  input  logic [ESZ_W-1:0]          esz,
  input  logic [TILE_W-1:0]         tile,
  input  logic [$clog2(SVL)-1:0]    slice,
  input  logic [SVL-1:0]            pred,
  output logic [$clog2(SVL)-1:0]    row,
  output logic [$clog2(SVL)-1:0]    col,
  output logic                      active
);
  localparam int IDX_W = $clog2(SVL);

  logic [IDX_W-1:0] emask;
  logic [IDX_W-1:0] lane_v;
  logic [IDX_W-1:0] base;

  always_comb begin
    case (esz)
      3'd0:    emask = IDX_W'(0);
      3'd1:    emask = IDX_W'(1);
      3'd2:    emask = IDX_W'(3);
      3'd3:    emask = IDX_W'(7);
      default: emask = IDX_W'(15);
    endcase
    lane_v = IDX_W'(LANE);
    base   = lane_v & ~emask;
    row    = base + IDX_W'(tile);
    col    = (slice << esz) + (lane_v & emask);
    active = pred[base];
  end
endmodule

// File: rtl/tsm_store.sv
// Byte matrix storage: masked row clear and per-lane scattered write,
// with per-lane gathered read of current contents.
module tsm_store
  import tsm_pkg::*;
#(
  parameter int SVL = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic                              zero_en,
  input  logic [MASK_W-1:0]                 zmask,
  input  logic [SVL-1:0][$clog2(SVL)-1:0]   lane_row,
  input  logic [SVL-1:0][$clog2(SVL)-1:0]   lane_col,
  input  logic [SVL-1:0]                    lane_act,
  input  logic [SVL-1:0][7:0]               lane_wdata,
  output logic [SVL-1:0][7:0]               lane_rdata
);
  logic [SVL-1:0][SVL-1:0][7:0] mem_q;
  logic [SVL-1:0][SVL-1:0][7:0] mem_d;
  logic                         mem_en;

  always_comb begin
    mem_d = mem_q;
    if (zero_en) begin
      for (int r = 0; r < SVL; r++) begin
        if (zmask[3'(r)]) mem_d[r] = '0;
      end
    end
    if (wr_en) begin
      for (int b = 0; b < SVL; b++) begin
        if (lane_act[b]) mem_d[lane_row[b]][lane_col[b]] = lane_wdata[b];
      end
    end
  end

  assign mem_en = wr_en | zero_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mem_q <= '0;
    else if (mem_en) mem_q <= mem_d;
  end

  always_comb begin
    for (int b = 0; b < SVL; b++) lane_rdata[b] = mem_q[lane_row[b]][lane_col[b]];
  end
endmodule

// File: rtl/interleaved_tile_mover.sv
module interleaved_tile_mover
  import tsm_pkg::*;
#(
  parameter int SVL = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic [1:0]                cmd_op,
  input  logic [ESZ_W-1:0]          cmd_esz,
  input  logic [TILE_W-1:0]         cmd_tile,
  input  logic [$clog2(SVL)-1:0]    cmd_slice,
  input  logic [MASK_W-1:0]         cmd_zmask,
  input  logic [SVL-1:0]            cmd_pred,
  input  logic [8*SVL-1:0]          cmd_vec,
  output logic                      done,
  output logic [8*SVL-1:0]          vec_out
);
  localparam int IDX_W = $clog2(SVL);
  localparam int VEC_W = 8 * SVL;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [SVL-1:0][IDX_W-1:0] lane_row;
  logic [SVL-1:0][IDX_W-1:0] lane_col;
  logic [SVL-1:0]            lane_act;
  logic [SVL-1:0][7:0]       lane_rd;
  logic [SVL-1:0][7:0]       lane_wd;

  assign lane_wd = cmd_vec;

  for (genvar g = 0; g < SVL; g++) begin : g_lane
    tsm_lane_map #(.SVL(SVL), .LANE(g)) u_map (
      .esz    (cmd_esz),
      .tile   (cmd_tile),
      .slice  (cmd_slice),
      .pred   (cmd_pred),
      .row    (lane_row[g]),
      .col    (lane_col[g]),
      .active (lane_act[g])
    );
  end

  logic wr_en, rd_en, zero_en;
  assign wr_en   = cmd_valid && (cmd_op == OP_COL_WR);
  assign rd_en   = cmd_valid && (cmd_op == OP_COL_RD);
  assign zero_en = cmd_valid && (cmd_op == OP_ZERO);

  tsm_store #(.SVL(SVL)) u_store (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_en),
    .zero_en    (zero_en),
    .zmask      (cmd_zmask),
    .lane_row   (lane_row),
    .lane_col   (lane_col),
    .lane_act   (lane_act),
    .lane_wdata (lane_wd),
    .lane_rdata (lane_rd)
  );

  // result merge: active lanes from storage, inactive lanes keep old value
  logic [VEC_W-1:0] vec_d;
  logic [VEC_W-1:0] vec_q;
  logic             done_q;

  always_comb begin
    for (int b = 0; b < SVL; b++) begin
      vec_d[b*8 +: 8] = lane_act[b] ? lane_rd[b] : cmd_vec[b*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      done_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      done_q <= cmd_valid;
      if (rd_en) vec_q <= vec_d;
    end
  end

  assign done    = done_q;
  assign vec_out = vec_q;
endmodule

// File: rtl/tsm_checker.sv
module tsm_checker
  import tsm_pkg::*;
#(
  parameter int SVL = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cmd_valid,
  input logic [1:0]             cmd_op,
  input logic [ESZ_W-1:0]       cmd_esz,
  input logic [TILE_W-1:0]      cmd_tile,
  input logic [$clog2(SVL)-1:0] cmd_slice,
  input logic [SVL-1:0]         cmd_pred,
  input logic [8*SVL-1:0]       cmd_vec,
  input logic                   done,
  input logic [8*SVL-1:0]       vec_out
);
  logic is_move;
  assign is_move = cmd_valid && (cmd_op == OP_COL_WR || cmd_op == OP_COL_RD);

  // R2: done follows every accepted command
  a_r2_done_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> done);

  // R2: no done without a command
  a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !done);

  // R10: result register only moves on a move-out
  a_r10_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_op == OP_COL_RD) |=> $stable(vec_out));

  // R5: fully inactive move-out returns the old destination value
  a_r5_inactive_keeps_dest: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_COL_RD && cmd_pred == '0) |=> vec_out == $past(cmd_vec));

  // R3: move commands name a legal size, tile and slice
  a_r3_legal_slot: assert property (@(posedge clk) disable iff (!rst_n)
    is_move |-> (cmd_esz <= 3'd4) && ((int'(cmd_tile) >> cmd_esz) == 0)
                && ((int'(cmd_slice) << cmd_esz) < SVL));
endmodule

bind interleaved_tile_mover tsm_checker #(.SVL(SVL)) u_tsm_checker (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_esz   (cmd_esz),
  .cmd_tile  (cmd_tile),
  .cmd_slice (cmd_slice),
  .cmd_pred  (cmd_pred),
  .cmd_vec   (cmd_vec),
  .done      (done),
  .vec_out   (vec_out)
);

// File: tb/tb_interleaved_tile_mover.sv
`timescale 1ns/1ps
module tb_interleaved_tile_mover;
  localparam int SVL   = 16;
  localparam int IDX_W = $clog2(SVL);
  localparam int VEC_W = 8 * SVL;
  localparam logic [SVL-1:0] ALL = '1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cmd_valid;
  logic [1:0]       cmd_op;
  logic [2:0]       cmd_esz;
  logic [3:0]       cmd_tile;
  logic [IDX_W-1:0] cmd_slice;
  logic [7:0]       cmd_zmask;
  logic [SVL-1:0]   cmd_pred;
  logic [VEC_W-1:0] cmd_vec;
  logic             done;
  logic [VEC_W-1:0] vec_out;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 0;
  logic [7:0] model [SVL][SVL];

  always #2 clk = ~clk;

  interleaved_tile_mover #(.SVL(SVL)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_esz(cmd_esz), .cmd_tile(cmd_tile), .cmd_slice(cmd_slice),
    .cmd_zmask(cmd_zmask), .cmd_pred(cmd_pred), .cmd_vec(cmd_vec),
    .done(done), .vec_out(vec_out)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [VEC_W-1:0] rnd_vec();
    logic [VEC_W-1:0] v;
    for (int i = 0; i < SVL / 4; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic void model_write(input int esz, input int tile, input int slice,
                                      input logic [SVL-1:0] pred, input logic [VEC_W-1:0] vec);
    int n = 1 << esz;
    for (int b = 0; b < SVL; b++) begin
      int base = b - (b % n);
      if (pred[base]) model[tile + base][slice * n + (b % n)] = vec[b*8 +: 8];
    end
  endfunction

  function automatic logic [VEC_W-1:0] model_read(input int esz, input int tile, input int slice,
                                                 input logic [SVL-1:0] pred,
                                                 input logic [VEC_W-1:0] vec);
    logic [VEC_W-1:0] r;
    int n = 1 << esz;
    for (int b = 0; b < SVL; b++) begin
      int base = b - (b % n);
      r[b*8 +: 8] = pred[base] ? model[tile + base][slice * n + (b % n)] : vec[b*8 +: 8];
    end
    return r;
  endfunction

  function automatic void model_zero(input logic [7:0] zm);
    for (int r = 0; r < SVL; r++)
      if (zm[r % 8]) for (int c = 0; c < SVL; c++) model[r][c] = 8'h00;
  endfunction

  // one command; checks the done pulse (R2) on the way
  task automatic send(input logic [1:0] op, input int esz, input int tile, input int slice,
                      input logic [7:0] zm, input logic [SVL-1:0] pred,
                      input logic [VEC_W-1:0] vec);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_esz = 3'(esz); cmd_tile = 4'(tile);
    cmd_slice = IDX_W'(slice); cmd_zmask = zm; cmd_pred = pred; cmd_vec = vec;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(done == 1'b1, "R2 done pulse", VEC_W'(done), VEC_W'(1));
    @(negedge clk);
    check(done == 1'b0, "R2 done drop", VEC_W'(done), VEC_W'(0));
  endtask

  task automatic do_write(input int esz, input int tile, input int slice,
                          input logic [SVL-1:0] pred, input logic [VEC_W-1:0] vec);
    send(2'b00, esz, tile, slice, 8'h00, pred, vec);
    model_write(esz, tile, slice, pred, vec);
  endtask

  task automatic do_read(input int esz, input int tile, input int slice,
                         input logic [SVL-1:0] pred, input logic [VEC_W-1:0] vec,
                         input string tag);
    logic [VEC_W-1:0] exp = model_read(esz, tile, slice, pred, vec);
    send(2'b01, esz, tile, slice, 8'h00, pred, vec);
    check(vec_out == exp, tag, vec_out, exp);
  endtask

  task automatic do_zero(input logic [7:0] zm);
    send(2'b10, 0, 0, 0, zm, '0, '0);
    model_zero(zm);
  endtask

  task automatic check_all(input string tag);
    for (int c = 0; c < SVL; c++) do_read(0, 0, c, ALL, rnd_vec(), tag);
  endtask

  task automatic fill_random();
    for (int c = 0; c < SVL; c++) do_write(0, 0, c, ALL, rnd_vec());
  endtask

  task automatic t_reset();
    check(done == 1'b0, "R1 done after reset", VEC_W'(done), '0);
    check(vec_out == '0, "R1 vec_out after reset", vec_out, '0);
    check_all("R1 storage zero");
  endtask

  task automatic t_sizes();
    for (int e = 0; e <= 4; e++) begin
      int n = 1 << e;
      do_write(e, n - 1, SVL / n - 1, ALL, rnd_vec());
      do_read(e, n - 1, SVL / n - 1, ALL, rnd_vec(), "R3 last tile slice");
      do_write(e, 0, 0, ALL, rnd_vec());
      do_read(e, 0, 0, ALL, rnd_vec(), "R3 first tile slice");
    end
    check_all("R3 mapping");
  endtask

  task automatic t_pred();
    fill_random();
    do_write(1, 1, 3, 16'b0100_0001_0001_0100, rnd_vec());
    check_all("R4 inactive unchanged");
    do_write(2, 2, 1, 16'h0000, rnd_vec());
    check_all("R4 empty predicate");
    do_read(2, 2, 1, 16'h0010, rnd_vec(), "R5 partial predicate");
    do_read(3, 5, 1, 16'h0100, rnd_vec(), "R5 upper element only");
    do_read(0, 0, 7, 16'h0000, rnd_vec(), "R5 no active element");
  endtask

  task automatic t_cross();
    logic [VEC_W-1:0] v = rnd_vec();
    do_write(2, 1, 0, ALL, v);
    do_read(0, 0, 0, ALL, rnd_vec(), "R6 byte view of word slice");
    check(vec_out[8 +: 8] == v[7:0], "R6 row1", VEC_W'(vec_out[8 +: 8]), VEC_W'(v[7:0]));
    check(vec_out[13*8 +: 8] == v[12*8 +: 8], "R6 row13",
          VEC_W'(vec_out[13*8 +: 8]), VEC_W'(v[12*8 +: 8]));
  endtask

  task automatic t_quad();
    logic [VEC_W-1:0] v = rnd_vec();
    do_write(4, 5, 0, ALL, v);
    do_read(3, 5, 0, ALL, rnd_vec(), "R9 low half");
    check(vec_out[63:0] == v[63:0], "R9 low 64", VEC_W'(vec_out[63:0]), VEC_W'(v[63:0]));
    do_read(3, 5, 1, ALL, rnd_vec(), "R9 high half");
    check(vec_out[63:0] == v[127:64], "R9 high 64", VEC_W'(vec_out[63:0]), VEC_W'(v[127:64]));
  endtask

  task automatic t_zero_mask();
    fill_random();
    do_zero(8'h21);
    check_all("R7 masked rows");
  endtask

  task automatic t_zero_all();
    fill_random();
    do_zero(8'hFF);
    check_all("R8 full clear");
    check(vec_out == '0, "R8 last column zero", vec_out, '0);
  endtask

  task automatic t_hold();
    logic [VEC_W-1:0] held;
    fill_random();
    do_read(1, 0, 2, ALL, rnd_vec(), "R10 prime result");
    held = vec_out;
    do_write(0, 0, 4, ALL, rnd_vec());
    check(vec_out == held, "R10 write keeps result", vec_out, held);
    do_zero(8'h00);
    check(vec_out == held, "R10 zero keeps result", vec_out, held);
    send(2'b11, 2, 3, 3, 8'hFF, ALL, rnd_vec());
    check(vec_out == held, "R10 reserved keeps result", vec_out, held);
    check_all("R10 reserved keeps storage");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < SVL; r++)
      for (int c = 0; c < SVL; c++) model[r][c] = 8'h00;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_esz = '0; cmd_tile = '0;
    cmd_slice = '0; cmd_zmask = '0; cmd_pred = '0; cmd_vec = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_sizes();
    t_pred();
    t_cross();
    t_quad();
    t_zero_mask();
    t_zero_all();
    t_hold();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule